// File: doc/BRIEF.md
# Eight-Bit Magnitude Comparator With Enables

This block compares two unsigned 8-bit magnitudes, P and Q, and answers two questions at once: whether they are identical, and whether P is strictly larger than Q. Each answer comes from its own section of logic, and each section has its own active-low enable. Both flags are active low. A section whose enable is inactive holds its flag high, whatever the data.

The block is purely combinational. The equality section forms a per-bit match vector and reduces it. The greater-than section builds one product term per bit position. Term k is true when P has a one and Q has a zero at position k, and every pair of bits above k matches. The terms are ORed and the result is inverted onto the output.

The block is used where two separate consumers need different comparison results and each must be able to silence its own result without affecting the other.

Top module: `mag_cmp8`

## Requirements
- R1: With the equality enable low, the equal flag is low whenever P and Q are bit-for-bit identical.
- R2: With the equality enable low, the equal flag is high whenever P and Q differ in any bit.
- R3: With the equality enable high, the equal flag is high for every value of P and Q.
- R4: With the greater enable low, the greater flag is low whenever P exceeds Q as an unsigned number.
- R5: With the greater enable low, the greater flag is high whenever P is less than or equal to Q.
- R6: With the greater enable high, the greater flag is high for every value of P and Q.
- R7: Each enable affects only its own flag. The level of the equality enable never changes the greater flag, and the level of the greater enable never changes the equal flag.
- R8: The equal flag and the greater flag are never low at the same time.
- R9: The greater decision depends only on the most significant bit position where P and Q differ. At most one of the per-position greater terms is true for any input pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| p_in | input | 8 | First unsigned operand |
| q_in | input | 8 | Second unsigned operand |
| eq_en_n | input | 1 | Equality section enable, active low |
| gt_en_n | input | 1 | Greater-than section enable, active low |
| eq_out_n | output | 1 | Low when enabled and P equals Q |
| gt_out_n | output | 1 | Low when enabled and P is greater than Q |

## Verification
The assertions check four things at every input change:
- The two flags are never low together.
- A disabled section keeps its flag high.
- A low flag agrees with an arithmetic comparison of the operands.
- At most one positional greater term is active.

The opposite direction cannot be shown by those assertions: that a flag does go low for every matching or larger operand pair. Independence between the enables cannot be shown by them either. The bench shows both by sweeping every operand pair under all four enable combinations, followed by directed priority cases and a seeded random phase.

// File: rtl/cmp_pkg.sv
package cmp_pkg;
    localparam int CMP_W = 8;

    typedef struct packed {
        logic eq_n;
        logic gt_n;
    } cmp_flags_t;
endpackage

// File: rtl/cmp_bit_match.sv
module cmp_bit_match #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] match_o
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign match_o[i] = ~(a_i[i] ^ b_i[i]);
    end
endmodule

// File: rtl/cmp_eq_section.sv
module cmp_eq_section #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] match_i,
    input  logic             en_n_i,
    output logic             eq_n_o
);
    logic all_match;

    always_comb begin
        all_match = &match_i;
        // NAND of the match bits with the active-high form of the enable
        eq_n_o    = ~(all_match & ~en_n_i);
    end
endmodule

// File: rtl/cmp_gt_section.sv
module cmp_gt_section #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [WIDTH-1:0] match_i,
    input  logic             en_n_i,
    output logic             gt_n_o
);
    logic [WIDTH-1:0] upper_eq;
    logic [WIDTH-1:0] term;

    for (genvar k = 0; k < WIDTH; k++) begin : g_term
        if (k == WIDTH - 1) begin : g_top
            assign upper_eq[k] = 1'b1;
        end else begin : g_low
            assign upper_eq[k] = &match_i[WIDTH-1:k+1];
        end
        // one AND term per position, wider toward the LSB
        assign term[k] = a_i[k] & ~b_i[k] & upper_eq[k] & ~en_n_i;
    end

    always_comb begin
        gt_n_o = ~(|term);
    end

    // R9: the positional terms are mutually exclusive
    always_comb begin
        p_single_term_r9: assert ($onehot0(term))
            else $error("R9: more than one greater term active");
    end
endmodule

// File: rtl/mag_cmp8.sv
module mag_cmp8 #(
    parameter int WIDTH = cmp_pkg::CMP_W
) (
    input  logic [WIDTH-1:0] p_in,
    input  logic [WIDTH-1:0] q_in,
    input  logic             eq_en_n,
    input  logic             gt_en_n,
    output logic             eq_out_n,
    output logic             gt_out_n
);
    import cmp_pkg::*;

    logic [WIDTH-1:0] match_vec;
    logic             eq_n_raw;
    logic             gt_n_raw;
    cmp_flags_t       flags_d;

    cmp_bit_match #(.WIDTH(WIDTH)) u_match (
        .a_i     (p_in),
        .b_i     (q_in),
        .match_o (match_vec)
    );

    cmp_eq_section #(.WIDTH(WIDTH)) u_eq (
        .match_i (match_vec),
        .en_n_i  (eq_en_n),
        .eq_n_o  (eq_n_raw)
    );

    cmp_gt_section #(.WIDTH(WIDTH)) u_gt (
        .a_i     (p_in),
        .b_i     (q_in),
        .match_i (match_vec),
        .en_n_i  (gt_en_n),
        .gt_n_o  (gt_n_raw)
    );

    always_comb begin
        flags_d      = '0;
        flags_d.eq_n = eq_n_raw;
        flags_d.gt_n = gt_n_raw;
    end

    assign eq_out_n = flags_d.eq_n;
    assign gt_out_n = flags_d.gt_n;

    always_comb begin
        p_excl_flags_r8: assert (eq_out_n | gt_out_n)
            else $error("R8: both flags low");
        p_eq_disabled_r3: assert (!eq_en_n || eq_out_n)
            else $error("R3: equal flag low while disabled");
        p_gt_disabled_r6: assert (!gt_en_n || gt_out_n)
            else $error("R6: greater flag low while disabled");
        p_eq_valid_r1: assert (eq_out_n || (p_in == q_in))
            else $error("R2: equal flag low on differing operands");
        p_gt_valid_r4: assert (gt_out_n || (p_in > q_in))
            else $error("R5: greater flag low with P not above Q");
    end
endmodule

// File: tb/mag_cmp8_tb_top.sv
module mag_cmp8_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] p_in = '0;
    logic [7:0] q_in = '0;
    logic       eq_en_n = 1'b1;
    logic       gt_en_n = 1'b1;
    logic       eq_out_n;
    logic       gt_out_n;
    int         n_run = 0;
    int         n_fail = 0;
    int         cyc = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            n_fail = n_fail + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=finish", cyc);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    mag_cmp8 dut_i (
        .p_in     (p_in),
        .q_in     (q_in),
        .eq_en_n  (eq_en_n),
        .gt_en_n  (gt_en_n),
        .eq_out_n (eq_out_n),
        .gt_out_n (gt_out_n)
    );

    function automatic logic exp_eq(int a, int b, logic en_n);
        if (en_n) return 1'b1;
        return (a == b) ? 1'b0 : 1'b1;
    endfunction

    function automatic logic exp_gt(int a, int b, logic en_n);
        if (en_n) return 1'b1;
        return (a > b) ? 1'b0 : 1'b1;
    endfunction

    function automatic string tag_eq(int a, int b, logic en_n, logic other);
        if (en_n) return other ? "R3" : "R3/R7";
        return (a == b) ? "R1/R7" : "R2/R7";
    endfunction

    function automatic string tag_gt(int a, int b, logic en_n);
        if (en_n) return "R6/R7";
        return (a > b) ? "R4/R9" : "R5";
    endfunction

    task automatic apply(input int a, input int b, input logic ee, input logic ge);
        logic xe;
        logic xg;
        p_in = a[7:0];
        q_in = b[7:0];
        eq_en_n = ee;
        gt_en_n = ge;
        #1;
        xe = exp_eq(a, b, ee);
        xg = exp_gt(a, b, ge);
        n_run = n_run + 1;
        if (eq_out_n !== xe) begin
            n_fail = n_fail + 1;
            $display("FAIL %s eq P=%0d Q=%0d en=%b%b: actual=%b expected=%b",
                     tag_eq(a, b, ee, ge), a, b, ee, ge, eq_out_n, xe);
        end
        n_run = n_run + 1;
        if (gt_out_n !== xg) begin
            n_fail = n_fail + 1;
            $display("FAIL %s gt P=%0d Q=%0d en=%b%b: actual=%b expected=%b",
                     tag_gt(a, b, ge), a, b, ee, ge, gt_out_n, xg);
        end
        n_run = n_run + 1;
        if (!eq_out_n && !gt_out_n) begin
            n_fail = n_fail + 1;
            $display("FAIL R8 P=%0d Q=%0d: actual=both low expected=not both", a, b);
        end
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        #3;
        rst_n = 1'b1;
        // initial state, both sections disabled: R3 and R6
        apply(0, 0, 1'b1, 1'b1);
        apply(255, 0, 1'b1, 1'b1);

        // directed priority corners: R9 and R4/R5
        apply(8'h80, 8'h7F, 1'b0, 1'b0);
        apply(8'h7F, 8'h80, 1'b0, 1'b0);
        apply(8'h01, 8'h00, 1'b0, 1'b0);
        apply(8'hFE, 8'hFF, 1'b0, 1'b0);
        apply(8'hFF, 8'hFF, 1'b0, 1'b0);
        apply(8'hA5, 8'hA4, 1'b0, 1'b0);
        apply(8'h00, 8'h00, 1'b0, 1'b0);

        // R7: toggle one enable while the other is held
        apply(8'h33, 8'h33, 1'b0, 1'b1);
        apply(8'h34, 8'h33, 1'b1, 1'b0);

        // exhaustive sweep of every operand pair under every enable combination
        for (int e = 0; e < 4; e++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b++) begin
                    apply(a, b, e[0], e[1]);
                end
            end
        end

        // seeded random phase
        for (int i = 0; i < 2000; i++) begin
            int a;
            int b;
            int e;
            a = $urandom() % 256;
            b = (i % 4 == 0) ? a : ($urandom() % 256);
            e = $urandom() % 4;
            apply(a, b, e[0], e[1]);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule